// File: doc/BRIEF.md
# Two-Wire Configuration Register Bank

This block is a serial-bus target that gives a host processor access to a small bank of configuration bytes and two read-only status bytes over a two-wire bus. It uses the widely used I2C framing. The block runs on a fast system clock and oversamples the bus clock and data lines. It drives the data line only through an open-drain pull-low enable. One bit of its 7-bit bus address comes from a strap input, so two copies can share one bus.

The host first writes a register pointer. Each further byte goes to the register the pointer names, and the pointer then steps forward. To read, the host writes the pointer, sends a repeated START and switches to read. The block returns bytes from the pointer onward until the host answers with a not-acknowledge. Every writable byte is presented in parallel on a flat output bus.

Two side functions are built in. A power-on flag in the first status byte stays set until that status byte has been read and the transaction has been closed with STOP. Writing the register that holds the last PLL word raises a one-cycle start pulse for a separate calibration engine, so the host writes that register last.

Top module: `cfgbus_i2c_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and the register bytes 0x00..0x0B on `cfg_o` (byte k at bits 8k+7..8k) hold 80, 23, 02, F6, 84, 01, C0, CC, 4B, 00, 00, 08 (hex).
- R2: The block acknowledges an address byte only if its upper 7 bits equal 110000 followed by `addr_sel`, so the write/read address bytes are C0/C1 when `addr_sel`=0 and C2/C3 when it is 1. Any other address gets no acknowledge, and the bytes that follow are neither acknowledged nor stored until the next START.
- R3: In a write, the first byte after the address is the pointer. Each later byte is stored at the pointer, which then increments. Every one of these bytes is acknowledged.
- R4: After a pointer write and a repeated START with R/W=1, the block returns the byte at the pointer MSB first and increments the pointer after each byte. A master acknowledge continues the read and a not-acknowledge ends it. A burst may run from the writable bytes into the status bytes.
- R5: Status byte 0x0C reads as {por, `stat_lo_i`[6:0]} and 0x0D reads as `stat_hi_i`. `por` is 1 after reset. It becomes 0 only once 0x0C has been sent in a transaction that then ends with STOP; a repeated START does not clear it.
- R6: Each byte stored at 0x04 gives exactly one single-cycle pulse on `cal_start`. Writes to other registers give none.
- R7: Bytes written to 0x0C and above are acknowledged but change nothing. Reads above 0x0D return 0x00.
- R8: A START or STOP in the middle of a byte ends the transfer. No register changes, and the pointer keeps its last value.
- R9: `sda_oe` is asserted only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_sel | input | 1 | Strap that sets the lowest address bit |
| stat_lo_i | input | 7 | Lower seven bits of status byte 0x0C |
| stat_hi_i | input | 8 | Status byte 0x0D |
| sda_oe | output | 1 | 1 pulls the data line low |
| cfg_o | output | 96 | Writable registers, byte k at bits 8k+7..8k |
| cal_start | output | 1 | One-cycle pulse after a write to 0x04 |

## Verification
A wrong pointer shows up within the same transaction: the next byte written lands in a neighbouring register on `cfg_o`, or the next byte read comes back from the wrong place. A state machine stuck after an address mismatch or a mid-byte abort shows up at the next acknowledge slot, where `sda_oe` stays low when it should pull or pulls when it should not. A power-on flag that clears too early or too late is seen on the next read of 0x0C. A lost or doubled calibration trigger is seen on `cal_start` within a cycle of the write.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_MACK
  } bus_state_e;

  function automatic logic [7:0] reset_value(input int idx);
    case (idx)
      0:  reset_value = 8'h80;
      1:  reset_value = 8'h23;
      2:  reset_value = 8'h02;
      3:  reset_value = 8'hF6;
      4:  reset_value = 8'h84;
      5:  reset_value = 8'h01;
      6:  reset_value = 8'hC0;
      7:  reset_value = 8'hCC;
      8:  reset_value = 8'h4B;
      11: reset_value = 8'h08;
      default: reset_value = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgbus_sync.sv
module cfgbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/cfgbus_regfile.sv
module cfgbus_regfile
  import cfgbus_pkg::*;
#(
  parameter int NUM_WR    = 12,
  parameter int TRIG_ADDR = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [7:0]               wr_addr,
  input  logic [7:0]               wr_data,
  input  logic [7:0]               rd_addr,
  input  logic [6:0]               stat_lo,
  input  logic [7:0]               stat_hi,
  input  logic                     por_clr,
  output logic [7:0]               rd_data,
  output logic [NUM_WR*BYTE_W-1:0] cfg_flat,
  output logic                     cal_pulse
);
  localparam logic [7:0] STAT0 = 8'(NUM_WR);
  localparam logic [7:0] STAT1 = 8'(NUM_WR + 1);
  localparam logic [7:0] TRIG  = 8'(TRIG_ADDR);

  logic por_q;

  for (genvar g = 0; g < NUM_WR; g++) begin : g_reg
    localparam logic [7:0] RV = reset_value(g);
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)                              q <= RV;
      else if (wr_en && wr_addr == 8'(g))   q <= wr_data;
    end
    assign cfg_flat[g*BYTE_W +: BYTE_W] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      por_q     <= 1'b1;
      cal_pulse <= 1'b0;
    end else begin
      if (por_clr) por_q <= 1'b0;
      cal_pulse <= wr_en && (wr_addr == TRIG);
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < NUM_WR; k++) begin
      if (rd_addr == 8'(k)) rd_data = cfg_flat[k*BYTE_W +: BYTE_W];
    end
    if (rd_addr == STAT0) rd_data = {por_q, stat_lo};
    if (rd_addr == STAT1) rd_data = stat_hi;
  end
endmodule

// File: rtl/cfgbus_link.sv
module cfgbus_link
  import cfgbus_pkg::*;
#(
  parameter logic [5:0] DEV_HI    = 6'b110000,
  parameter int         STAT_ADDR = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda,
  input  logic       sda_rise,
  input  logic       sda_fall,
  input  logic       addr_sel,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] ptr,
  output logic       por_clr
);
  localparam logic [7:0] STAT = 8'(STAT_ADDR);

  bus_state_e state, nxt;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [7:0] tx;
  logic       mack;
  logic       st_read;

  wire start_c = scl & sda_fall;
  wire stop_c  = scl & sda_rise;

  always_ff @(posedge clk) begin
    wr_en   <= 1'b0;
    por_clr <= 1'b0;
    if (rst) begin
      state   <= ST_IDLE;
      nxt     <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      mack    <= 1'b0;
      st_read <= 1'b0;
      sda_oe  <= 1'b0;
      ptr     <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (start_c) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state   <= ST_IDLE;
      sda_oe  <= 1'b0;
      por_clr <= st_read;
      st_read <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise && cnt < 4'd8) begin
            sh  <= {sh[6:0], sda};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (state == ST_ADDR) begin
              if (sh[7:1] == {DEV_HI, addr_sel}) begin
                sda_oe <= 1'b1;
                nxt    <= sh[0] ? ST_TX : ST_PTR;
                state  <= ST_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_PTR) begin
              ptr    <= sh;
              sda_oe <= 1'b1;
              nxt    <= ST_WDATA;
              state  <= ST_ACK;
            end else begin
              wr_en   <= 1'b1;
              wr_addr <= ptr;
              wr_data <= sh;
              ptr     <= ptr + 8'd1;
              sda_oe  <= 1'b1;
              nxt     <= ST_WDATA;
              state   <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (nxt == ST_TX) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
              ptr    <= ptr + 8'd1;
              if (ptr == STAT) st_read <= 1'b1;
            end else begin
              sda_oe <= 1'b0;
            end
            state <= nxt;
          end
        end
        ST_TX: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack <= ~sda;
          if (scl_fall) begin
            cnt <= '0;
            if (mack) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
              ptr    <= ptr + 8'd1;
              if (ptr == STAT) st_read <= 1'b1;
              state  <= ST_TX;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfgbus_i2c_slave.sv
module cfgbus_i2c_slave
  import cfgbus_pkg::*;
#(
  parameter int NUM_WR      = 12,
  parameter int TRIG_ADDR   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     scl_i,
  input  logic                     sda_i,
  input  logic                     addr_sel,
  input  logic [6:0]               stat_lo_i,
  input  logic [7:0]               stat_hi_i,
  output logic                     sda_oe,
  output logic [NUM_WR*BYTE_W-1:0] cfg_o,
  output logic                     cal_start
);
  logic scl_l, scl_r, scl_f;
  logic sda_l, sda_r, sda_f;
  logic wr_en, por_clr;
  logic [7:0] wr_addr, wr_data, ptr, rd_data;

  cfgbus_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst(rst), .din(scl_i), .level(scl_l), .rise(scl_r), .fall(scl_f));

  cfgbus_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst(rst), .din(sda_i), .level(sda_l), .rise(sda_r), .fall(sda_f));

  cfgbus_link #(.STAT_ADDR(NUM_WR)) u_link (
    .clk(clk), .rst(rst),
    .scl(scl_l), .scl_rise(scl_r), .scl_fall(scl_f),
    .sda(sda_l), .sda_rise(sda_r), .sda_fall(sda_f),
    .addr_sel(addr_sel), .rd_data(rd_data),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr(ptr), .por_clr(por_clr));

  cfgbus_regfile #(.NUM_WR(NUM_WR), .TRIG_ADDR(TRIG_ADDR)) u_rf (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .stat_lo(stat_lo_i), .stat_hi(stat_hi_i),
    .por_clr(por_clr), .rd_data(rd_data),
    .cfg_flat(cfg_o), .cal_pulse(cal_start));
endmodule

// File: rtl/cfgbus_chk.sv
module cfgbus_chk #(
  parameter int CFG_W = 96
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_i,
  input logic             sda_oe,
  input logic [CFG_W-1:0] cfg_o,
  input logic             cal_start
);
  // R1: bus released on the first cycle after reset
  p_oe_released_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sda_oe);

  // R6: trigger is a single-cycle pulse
  p_cal_single_r6: assert property (@(posedge clk) disable iff (rst)
    cal_start |=> !cal_start);

  // R6: trigger only ever fires after a byte has ended, bus clock low
  p_cal_scl_low_r6: assert property (@(posedge clk) disable iff (rst)
    cal_start |-> !scl_i);

  // R3: stored bytes change only while the bus clock is low
  p_cfg_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> !scl_i);

  // R9: data line is pulled only while the bus clock is low
  p_oe_rise_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);
endmodule

bind cfgbus_i2c_slave cfgbus_chk #(.CFG_W(NUM_WR*8)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .cfg_o(cfg_o), .cal_start(cal_start));

// File: tb/sim_cfgbus_i2c_slave.sv
module sim_cfgbus_i2c_slave;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic [6:0] stat_lo = 7'h55;
  logic [7:0] stat_hi = 8'hA6;
  logic sda_oe, cal_start;
  logic [95:0] cfg;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0, cal_cnt = 0, oe_viol = 0;
  logic oe_prev = 1'b0;
  bit done = 0;

  logic [7:0] model [12] = '{8'h80, 8'h23, 8'h02, 8'hF6, 8'h84, 8'h01,
                              8'hC0, 8'hCC, 8'h4B, 8'h00, 8'h00, 8'h08};

  always #5 clk = ~clk;

  cfgbus_i2c_slave u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .addr_sel(addr_sel),
    .stat_lo_i(stat_lo), .stat_hi_i(stat_hi), .sda_oe(sda_oe),
    .cfg_o(cfg), .cal_start(cal_start));

  always @(posedge clk) begin
    if (!rst && cal_start) cal_cnt++;
    if (!rst && sda_oe && !oe_prev && scl) oe_viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (HP) @(negedge clk);
  endtask

  task automatic b_start();
    half(); sda_m = 1'b1; half(); scl = 1'b1; half(); sda_m = 1'b0; half(); scl = 1'b0;
  endtask

  task automatic b_stop();
    half(); sda_m = 1'b0; half(); scl = 1'b1; half(); sda_m = 1'b1; half();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      half(); sda_m = b[i]; half(); scl = 1'b1; half(); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    half(); sda_m = 1'b1; half(); scl = 1'b1; half();
    ack = ~sda_line;
    scl = 1'b0;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      half(); sda_m = 1'b1; half(); scl = 1'b1; half();
      b[i] = sda_line;
      scl = 1'b0;
    end
    half(); sda_m = ~m_ack; half(); scl = 1'b1; half(); scl = 1'b0;
  endtask

  task automatic chk_cfg(input string req);
    for (int k = 0; k < 12; k++) chk(req, {24'h0, cfg[k*8 +: 8]}, {24'h0, model[k]});
  endtask

  // R1
  task automatic t_reset();
    chk("R1 sda_oe", {31'h0, sda_oe}, 32'h0);
    chk_cfg("R1 defaults");
  endtask

  // R2
  task automatic t_addr();
    logic a;
    addr_sel = 1'b0;
    b_start(); send_byte(8'hC2, a); chk("R2 mismatch nack", {31'h0, a}, 32'h0);
    send_byte(8'h05, a); chk("R2 ignored ptr", {31'h0, a}, 32'h0);
    send_byte(8'hAA, a); chk("R2 ignored data", {31'h0, a}, 32'h0);
    b_stop();
    chk("R2 no write", {24'h0, cfg[5*8 +: 8]}, {24'h0, model[5]});
    b_start(); send_byte(8'hC0, a); chk("R2 C0 ack", {31'h0, a}, 32'h1); b_stop();
    addr_sel = 1'b1;
    b_start(); send_byte(8'hC2, a); chk("R2 C2 ack", {31'h0, a}, 32'h1); b_stop();
    b_start(); send_byte(8'hC0, a); chk("R2 C0 nack", {31'h0, a}, 32'h0); b_stop();
    addr_sel = 1'b0;
  endtask

  // R3, R6
  task automatic t_write();
    logic a;
    int c0 = cal_cnt;
    b_start(); send_byte(8'hC0, a);
    send_byte(8'h02, a); chk("R3 ptr ack", {31'h0, a}, 32'h1);
    send_byte(8'h11, a); chk("R3 d0 ack", {31'h0, a}, 32'h1);
    send_byte(8'h22, a); chk("R3 d1 ack", {31'h0, a}, 32'h1);
    send_byte(8'h33, a); chk("R3 d2 ack", {31'h0, a}, 32'h1);
    b_stop();
    model[2] = 8'h11; model[3] = 8'h22; model[4] = 8'h33;
    chk_cfg("R3 burst write");
    chk("R6 one pulse", cal_cnt - c0, 32'd1);
    c0 = cal_cnt;
    b_start(); send_byte(8'hC0, a); send_byte(8'h03, a); send_byte(8'h44, a); b_stop();
    model[3] = 8'h44;
    chk("R6 no pulse for 0x03", cal_cnt - c0, 32'd0);
    chk("R3 single write", {24'h0, cfg[3*8 +: 8]}, 32'h44);
  endtask

  // R4
  task automatic t_read();
    logic a; logic [7:0] b;
    b_start(); send_byte(8'hC0, a); send_byte(8'h01, a);
    b_start(); send_byte(8'hC1, a); chk("R4 read addr ack", {31'h0, a}, 32'h1);
    recv_byte(1'b1, b); chk("R4 byte0", {24'h0, b}, 32'h23);
    recv_byte(1'b1, b); chk("R4 byte1", {24'h0, b}, 32'h11);
    recv_byte(1'b0, b); chk("R4 byte2", {24'h0, b}, 32'h44);
    b_stop();
  endtask

  // R4, R5
  task automatic t_status();
    logic a; logic [7:0] b;
    b_start(); send_byte(8'hC0, a); send_byte(8'h0B, a);
    b_start(); send_byte(8'hC1, a);
    recv_byte(1'b1, b); chk("R4 cross 0x0B", {24'h0, b}, 32'h08);
    recv_byte(1'b1, b); chk("R5 por set", {24'h0, b}, 32'hD5);
    recv_byte(1'b0, b); chk("R5 stat_hi", {24'h0, b}, 32'hA6);
    b_start(); send_byte(8'hC0, a); send_byte(8'h0C, a);
    b_start(); send_byte(8'hC1, a);
    recv_byte(1'b0, b); chk("R5 kept over restart", {24'h0, b}, 32'hD5);
    b_stop();
    b_start(); send_byte(8'hC0, a); send_byte(8'h0C, a);
    b_start(); send_byte(8'hC1, a);
    recv_byte(1'b0, b); chk("R5 cleared after stop", {24'h0, b}, 32'h55);
    b_stop();
  endtask

  // R7
  task automatic t_readonly();
    logic a; logic [7:0] b;
    b_start(); send_byte(8'hC0, a); send_byte(8'h0C, a);
    send_byte(8'h77, a); chk("R7 ack 0x0C", {31'h0, a}, 32'h1);
    send_byte(8'h99, a); chk("R7 ack 0x0D", {31'h0, a}, 32'h1);
    send_byte(8'h44, a); chk("R7 ack 0x0E", {31'h0, a}, 32'h1);
    b_stop();
    chk_cfg("R7 no side effect");
    b_start(); send_byte(8'hC0, a); send_byte(8'h0D, a);
    b_start(); send_byte(8'hC1, a);
    recv_byte(1'b1, b); chk("R7 0x0D unchanged", {24'h0, b}, 32'hA6);
    recv_byte(1'b0, b); chk("R7 0x0E zero", {24'h0, b}, 32'h00);
    b_stop();
  endtask

  // R8
  task automatic t_abort();
    logic a; logic [7:0] b;
    int c0 = cal_cnt;
    b_start(); send_byte(8'hC0, a); send_byte(8'h06, a);
    send_bits(8'h5A, 4); b_stop();
    chk("R8 stop mid-byte", {24'h0, cfg[6*8 +: 8]}, 32'hC0);
    b_start(); send_byte(8'hC0, a); send_byte(8'h04, a);
    send_bits(8'h3C, 3);
    b_start(); send_byte(8'hC1, a);
    recv_byte(1'b0, b); chk("R8 ptr kept", {24'h0, b}, 32'h33);
    b_stop();
    chk_cfg("R8 no corruption");
    chk("R8 no trigger", cal_cnt - c0, 32'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_addr();
    t_write();
    t_read();
    t_status();
    t_readonly();
    t_abort();
    chk("R9 oe while scl high", oe_viol, 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule